// File: doc/BRIEF.md
# Bus Response Timeout Monitor

This block sits beside a single-transaction on-chip bus and guards every access against a slave that never answers. When a master starts an access, the monitor records who issued it, the direction and the address. It then counts bus clock cycles until the slave raises its response strobe. If the programmed limit runs out first, the monitor completes the access itself with a one-cycle error response. This frees the bus, latches the faulting address and reports the fault in the way that suits the issuing master.

Master ID 0 is the processor. A processor read that times out comes back as a bus error pulse beside the error response. A processor write that times out sets a sticky status flag, which can raise an interrupt request when enabled. Any other master that times out sets its own sticky flag, which is brought out as that master's interrupt line. Detection is forced off while a debug probe is attached. A small register port holds the control word, the status flags and the captured address.

Top module: `bus_timeout_monitor`

## Requirements
- R1: While control bit 0 (enable) is clear, no error response is ever produced, and an access stays pending until the slave responds, however long that takes.
- R2: With control bits [2:1] = n, an unanswered access receives its error response in the cycle after it has waited 2^(BASE_EXP+STEP_EXP*n) - 1 cycles, that is in wait cycle number 2^(BASE_EXP+STEP_EXP*n), counting the first cycle after the start is accepted as 1.
- R3: The error response is a single-cycle pulse that ends the access. A slave response in the same cycle as expiry wins, and then no error is produced or logged.
- R4: The fault-address register (register offset 2) loads the address of a timed-out access only when no status flag is set. It holds its value while any status flag is set.
- R5: A timeout of master 0 on a write sets status bit 0, and the output cpu_wr_irq equals status bit 0 AND control bit 3.
- R6: A timeout of master 0 on a read pulses cpu_rd_err in the same cycle as the error response and sets no status bit.
- R7: A timeout of master m (m > 0) sets status bit m (register offset 1), and mst_err_irq[m] follows that bit.
- R8: While dbg_probe is high, no error response is produced, whatever the enable bit holds.
- R9: Status bits are sticky. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a set in the same cycle takes priority over the clear.
- R10: After reset the control word, the status flags and the fault address read 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Access begins (accepted while idle) |
| bus_mid | input | MID_W | ID of the master issuing the access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Address of the access |
| slv_ack | input | 1 | Slave response strobe |
| dbg_probe | input | 1 | Debug probe attached, suppresses detection |
| err_resp | output | 1 | Forced error completion pulse |
| cpu_rd_err | output | 1 | Bus error pulse to the processor on a read timeout |
| cpu_wr_irq | output | 1 | Interrupt request for a processor write timeout |
| mst_err_irq | output | 2**MID_W-1 | Per-master error flags, indexed 1 to 2**MID_W-1 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 status, 2 fault address |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for reg_addr |

## Verification
The bench builds the monitor with BASE_EXP=2 and STEP_EXP=1, so the four limits become 4, 8, 16 and 32 cycles. With these values every timeout select, the tie between slave response and expiry, and a late response just past the limit all fit into a short run. MID_W keeps its default of 2, which gives the processor and three other masters. Every routing path and every per-master flag is therefore reached.

// File: rtl/btm_pkg.sv
package btm_pkg;

    localparam int TSEL_W        = 2;
    localparam int CPU_ID        = 0;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_TSEL_LSB = 1;
    localparam int CTRL_IE_BIT   = 3;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_STAT  = 2'd1,
        REG_FADDR = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ROUTE_NONE   = 2'd0,
        ROUTE_CPU_WR = 2'd1,
        ROUTE_CPU_RD = 2'd2,
        ROUTE_MST    = 2'd3
    } route_e;

    function automatic int unsigned limit_shift(int unsigned base,
                                                int unsigned step,
                                                logic [TSEL_W-1:0] sel);
        return base + step * int'(unsigned'(sel));
    endfunction

endpackage

// File: rtl/btm_timer.sv
module btm_timer
    import btm_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MID_W    = 2,
    parameter int BASE_EXP = 8,
    parameter int STEP_EXP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MID_W-1:0]  mid,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              slv_ack,
    input  logic              active,
    input  logic [TSEL_W-1:0] tsel,
    output logic              busy,
    output logic              expire,
    output logic [MID_W-1:0]  pend_mid,
    output logic              pend_wr,
    output logic [ADDR_W-1:0] pend_addr
);
    localparam int CNT_W = BASE_EXP + 3 * STEP_EXP + 1;

    typedef struct packed {
        logic [MID_W-1:0]  mid;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } pend_t;

    pend_t            pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m1;
    logic             busy_q;

    always_comb begin
        lim_m1 = (CNT_W'(1) << limit_shift(BASE_EXP, STEP_EXP, tsel)) - CNT_W'(1);
    end

    assign expire = busy_q && active && !slv_ack && (cnt_q >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            pend_q <= '0;
        end else if (!busy_q) begin
            cnt_q <= '0;
            if (start) begin
                busy_q <= 1'b1;
                pend_q <= '{mid: mid, wr: wr, addr: addr};
            end
        end else if (slv_ack || expire) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign busy      = busy_q;
    assign pend_mid  = pend_q.mid;
    assign pend_wr   = pend_q.wr;
    assign pend_addr = pend_q.addr;

endmodule

// File: rtl/btm_route.sv
module btm_route
    import btm_pkg::*;
#(
    parameter int MID_W = 2,
    localparam int NUM_MASTERS = 2 ** MID_W
) (
    input  logic                   expire,
    input  logic [MID_W-1:0]       pend_mid,
    input  logic                   pend_wr,
    output logic [NUM_MASTERS-1:0] set_vec,
    output logic                   cpu_rd
);
    route_e kind;

    always_comb begin
        kind = ROUTE_NONE;
        if (expire) begin
            if (pend_mid == MID_W'(CPU_ID)) begin
                kind = pend_wr ? ROUTE_CPU_WR : ROUTE_CPU_RD;
            end else begin
                kind = ROUTE_MST;
            end
        end
    end

    always_comb begin
        set_vec = '0;
        cpu_rd  = 1'b0;
        case (kind)
            ROUTE_CPU_WR: set_vec[CPU_ID]   = 1'b1;
            ROUTE_CPU_RD: cpu_rd            = 1'b1;
            ROUTE_MST:    set_vec[pend_mid] = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/btm_regs.sv
module btm_regs
    import btm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MID_W  = 2,
    localparam int NUM_MASTERS = 2 ** MID_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_we,
    input  logic [1:0]             reg_addr,
    input  logic [ADDR_W-1:0]      reg_wdata,
    output logic [ADDR_W-1:0]      reg_rdata,
    input  logic [NUM_MASTERS-1:0] set_vec,
    input  logic                   cap_valid,
    input  logic [ADDR_W-1:0]      cap_addr,
    output logic                   ctrl_en,
    output logic [TSEL_W-1:0]      ctrl_tsel,
    output logic                   ctrl_ie,
    output logic [NUM_MASTERS-1:0] stat,
    output logic [ADDR_W-1:0]      fault_addr
);
    logic                   en_q;
    logic                   ie_q;
    logic [TSEL_W-1:0]      tsel_q;
    logic [NUM_MASTERS-1:0] stat_q;
    logic [NUM_MASTERS-1:0] clr_vec;
    logic [ADDR_W-1:0]      faddr_q;
    reg_sel_e               sel;
    logic                   unused_wdata;

    assign sel          = reg_sel_e'(reg_addr);
    assign unused_wdata = ^reg_wdata;
    assign clr_vec      = (reg_we && sel == REG_STAT) ? reg_wdata[NUM_MASTERS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
            tsel_q <= '0;
        end else if (reg_we && sel == REG_CTRL) begin
            en_q   <= reg_wdata[CTRL_EN_BIT];
            ie_q   <= reg_wdata[CTRL_IE_BIT];
            tsel_q <= reg_wdata[CTRL_TSEL_LSB +: TSEL_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | set_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            faddr_q <= '0;
        end else if (cap_valid && stat_q == '0) begin
            faddr_q <= cap_addr;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            REG_CTRL: begin
                reg_rdata[CTRL_EN_BIT]                = en_q;
                reg_rdata[CTRL_TSEL_LSB +: TSEL_W]    = tsel_q;
                reg_rdata[CTRL_IE_BIT]                = ie_q;
            end
            REG_STAT:  reg_rdata[NUM_MASTERS-1:0] = stat_q;
            REG_FADDR: reg_rdata = faddr_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign ctrl_en    = en_q;
    assign ctrl_ie    = ie_q;
    assign ctrl_tsel  = tsel_q;
    assign stat       = stat_q;
    assign fault_addr = faddr_q;

endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor
    import btm_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MID_W    = 2,
    parameter int BASE_EXP = 8,
    parameter int STEP_EXP = 2,
    localparam int NUM_MASTERS = 2 ** MID_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_start,
    input  logic [MID_W-1:0]       bus_mid,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   slv_ack,
    input  logic                   dbg_probe,
    output logic                   err_resp,
    output logic                   cpu_rd_err,
    output logic                   cpu_wr_irq,
    output logic [NUM_MASTERS-1:1] mst_err_irq,
    input  logic                   reg_we,
    input  logic [1:0]             reg_addr,
    input  logic [ADDR_W-1:0]      reg_wdata,
    output logic [ADDR_W-1:0]      reg_rdata
);
    logic                   ctrl_en;
    logic                   ctrl_ie;
    logic [TSEL_W-1:0]      ctrl_tsel;
    logic                   active;
    logic                   busy;
    logic                   expire;
    logic [MID_W-1:0]       pend_mid;
    logic                   pend_wr;
    logic [ADDR_W-1:0]      pend_addr;
    logic [NUM_MASTERS-1:0] set_vec;
    logic [NUM_MASTERS-1:0] stat_vec;
    logic [ADDR_W-1:0]      fault_addr;
    logic                   unused_busy;

    assign active      = ctrl_en && !dbg_probe;
    assign unused_busy = busy;

    btm_timer #(
        .ADDR_W  (ADDR_W),
        .MID_W   (MID_W),
        .BASE_EXP(BASE_EXP),
        .STEP_EXP(STEP_EXP)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (bus_start),
        .mid      (bus_mid),
        .wr       (bus_write),
        .addr     (bus_addr),
        .slv_ack  (slv_ack),
        .active   (active),
        .tsel     (ctrl_tsel),
        .busy     (busy),
        .expire   (expire),
        .pend_mid (pend_mid),
        .pend_wr  (pend_wr),
        .pend_addr(pend_addr)
    );

    btm_route #(
        .MID_W(MID_W)
    ) u_route (
        .expire  (expire),
        .pend_mid(pend_mid),
        .pend_wr (pend_wr),
        .set_vec (set_vec),
        .cpu_rd  (cpu_rd_err)
    );

    btm_regs #(
        .ADDR_W(ADDR_W),
        .MID_W (MID_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .set_vec   (set_vec),
        .cap_valid (expire),
        .cap_addr  (pend_addr),
        .ctrl_en   (ctrl_en),
        .ctrl_tsel (ctrl_tsel),
        .ctrl_ie   (ctrl_ie),
        .stat      (stat_vec),
        .fault_addr(fault_addr)
    );

    assign err_resp    = expire;
    assign cpu_wr_irq  = stat_vec[CPU_ID] && ctrl_ie;
    assign mst_err_irq = stat_vec[NUM_MASTERS-1:1];

endmodule

// File: rtl/btm_checker.sv
module btm_checker #(
    parameter int ADDR_W      = 32,
    parameter int NUM_MASTERS = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   slv_ack,
    input logic                   dbg_probe,
    input logic                   err_resp,
    input logic                   cpu_rd_err,
    input logic [NUM_MASTERS-1:1] mst_err_irq,
    input logic                   ctrl_en,
    input logic [NUM_MASTERS-1:0] stat_vec,
    input logic [ADDR_W-1:0]      fault_addr,
    input logic                   reg_we,
    input logic [1:0]             reg_addr
);
    a_r1_off_no_error: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> !err_resp);

    a_r3_ack_wins: assert property (@(posedge clk) disable iff (rst)
        slv_ack |-> !err_resp);

    a_r4_addr_held: assert property (@(posedge clk) disable iff (rst)
        (stat_vec != '0) |=> $stable(fault_addr));

    a_r6_rd_err_pair: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_err |-> err_resp);

    a_r7_flag_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(|mst_err_irq) |-> $past(err_resp));

    a_r8_probe_quiet: assert property (@(posedge clk) disable iff (rst)
        dbg_probe |-> !err_resp);

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_vec != '0) && !(reg_we && reg_addr == 2'd1)
        |=> ((stat_vec & $past(stat_vec)) == $past(stat_vec)));

endmodule

bind bus_timeout_monitor btm_checker #(
    .ADDR_W     (ADDR_W),
    .NUM_MASTERS(NUM_MASTERS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slv_ack    (slv_ack),
    .dbg_probe  (dbg_probe),
    .err_resp   (err_resp),
    .cpu_rd_err (cpu_rd_err),
    .mst_err_irq(mst_err_irq),
    .ctrl_en    (ctrl_en),
    .stat_vec   (stat_vec),
    .fault_addr (fault_addr),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr)
);

// File: tb/bus_timeout_monitor_tb.sv
module bus_timeout_monitor_tb;

    localparam int ADDR_W = 32;
    localparam int MID_W  = 2;
    localparam int NM     = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_start = 1'b0;
    logic [MID_W-1:0]  bus_mid = '0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              slv_ack = 1'b0;
    logic              dbg_probe = 1'b0;
    logic              err_resp;
    logic              cpu_rd_err;
    logic              cpu_wr_irq;
    logic [NM-1:1]     mst_err_irq;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_addr = '0;
    logic [ADDR_W-1:0] reg_wdata = '0;
    logic [ADDR_W-1:0] reg_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bus_timeout_monitor #(
        .ADDR_W  (ADDR_W),
        .MID_W   (MID_W),
        .BASE_EXP(2),
        .STEP_EXP(1)
    ) u_dut (
        .clk(clk), .rst(rst), .bus_start(bus_start), .bus_mid(bus_mid),
        .bus_write(bus_write), .bus_addr(bus_addr), .slv_ack(slv_ack),
        .dbg_probe(dbg_probe), .err_resp(err_resp), .cpu_rd_err(cpu_rd_err),
        .cpu_wr_irq(cpu_wr_irq), .mst_err_irq(mst_err_irq), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [1:0]  tsel;
        logic [1:0]  mid;
        logic        wr;
        logic [31:0] addr;
        logic [7:0]  ack_at;
        logic [7:0]  exp_cyc;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 2'd0, 1'b1, 32'h1000_0000, 8'd0,  8'd4},
        '{2'd1, 2'd0, 1'b0, 32'h1000_0040, 8'd3,  8'd0},
        '{2'd1, 2'd2, 1'b0, 32'h2000_0080, 8'd0,  8'd8},
        '{2'd2, 2'd1, 1'b1, 32'h3000_00C0, 8'd16, 8'd0},
        '{2'd2, 2'd3, 1'b1, 32'h4000_0100, 8'd17, 8'd16},
        '{2'd3, 2'd0, 1'b0, 32'h5000_0140, 8'd0,  8'd32},
        '{2'd0, 2'd1, 1'b0, 32'h6000_0180, 8'd1,  8'd0},
        '{2'd3, 2'd2, 1'b1, 32'h7000_01C0, 8'd31, 8'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run_access(input logic [1:0] mid, input logic wr, input logic [31:0] a,
                              input int ack_at, output int err_cyc, output int rd_cyc,
                              output int n_pulse);
        @(negedge clk);
        bus_start = 1'b1; bus_mid = mid; bus_write = wr; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_start = 1'b0;
        err_cyc = 0; rd_cyc = 0; n_pulse = 0;
        for (int k = 1; k <= 40; k++) begin
            slv_ack = (k == ack_at);
            #1;
            if (err_resp) begin
                n_pulse++;
                if (err_cyc == 0) err_cyc = k;
            end
            if (cpu_rd_err && rd_cyc == 0) rd_cyc = k;
            @(negedge clk);
        end
        slv_ack = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] exp_addr;
        logic [31:0] exp_stat;
        int ec, rc, np;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        reg_read(2'd0, rd); chk("R10 ctrl", rd, 0);
        reg_read(2'd1, rd); chk("R10 status", rd, 0);
        reg_read(2'd2, rd); chk("R10 fault addr", rd, 0);
        chk("R10 outputs", {err_resp, cpu_rd_err, cpu_wr_irq, mst_err_irq}, 0);

        // Vector walk: R2, R3, R4, R5, R6, R7, R9
        exp_addr = 0;
        foreach (VECS[i]) begin
            reg_write(2'd0, {28'd0, 1'b1, VECS[i].tsel, 1'b1});
            run_access(VECS[i].mid, VECS[i].wr, VECS[i].addr, int'(VECS[i].ack_at), ec, rc, np);
            chk("R2 error cycle", ec, VECS[i].exp_cyc);
            chk("R3 pulse count", np, (VECS[i].exp_cyc != 0) ? 1 : 0);
            chk("R6 cpu read error cycle", rc,
                (VECS[i].mid == 0 && !VECS[i].wr) ? VECS[i].exp_cyc : 0);
            exp_stat = 0;
            if (VECS[i].exp_cyc != 0) begin
                exp_addr = VECS[i].addr;
                if (VECS[i].mid != 0) exp_stat = 32'd1 << VECS[i].mid;
                else if (VECS[i].wr)  exp_stat = 32'd1;
            end
            reg_read(2'd1, rd); chk("R5 R7 status", rd, exp_stat);
            chk("R5 cpu_wr_irq", cpu_wr_irq, exp_stat[0]);
            chk("R7 mst_err_irq", mst_err_irq, exp_stat[3:1]);
            reg_read(2'd2, rd); chk("R4 fault addr", rd, exp_addr);
            reg_write(2'd1, 32'hF);
            reg_read(2'd1, rd); chk("R9 clear all", rd, 0);
        end

        // R1: disabled, access waits past every limit until the slave answers
        reg_write(2'd0, 32'd0);
        run_access(2'd1, 1'b1, 32'hA000_0000, 30, ec, rc, np);
        chk("R1 no error while disabled", ec, 0);
        reg_read(2'd1, rd); chk("R1 status untouched", rd, 0);

        // R8: probe attached overrides enable
        reg_write(2'd0, 32'h1);
        dbg_probe = 1'b1;
        run_access(2'd2, 1'b0, 32'hB000_0000, 30, ec, rc, np);
        chk("R8 no error with probe", ec, 0);
        dbg_probe = 1'b0;
        reg_read(2'd1, rd); chk("R8 status untouched", rd, 0);

        // R4 / R5 / R9: address hold across several faults
        reg_write(2'd0, 32'h1);
        run_access(2'd0, 1'b1, 32'hC000_0010, 0, ec, rc, np);
        chk("R2 limit 4 again", ec, 4);
        run_access(2'd1, 1'b0, 32'hC000_0020, 0, ec, rc, np);
        reg_read(2'd2, rd); chk("R4 first fault held", rd, 32'hC000_0010);
        reg_read(2'd1, rd); chk("R9 sticky both", rd, 32'h3);
        chk("R5 irq masked", cpu_wr_irq, 1'b0);
        reg_write(2'd0, 32'h9);
        #1 chk("R5 irq enabled", cpu_wr_irq, 1'b1);
        reg_write(2'd1, 32'h0);
        reg_read(2'd1, rd); chk("R9 write zero keeps", rd, 32'h3);
        reg_write(2'd1, 32'h1);
        reg_read(2'd1, rd); chk("R9 partial clear", rd, 32'h2);
        chk("R5 irq drops", cpu_wr_irq, 1'b0);
        chk("R7 master1 flag", mst_err_irq, 3'b001);
        run_access(2'd3, 1'b1, 32'hC000_0030, 0, ec, rc, np);
        reg_read(2'd2, rd); chk("R4 still held", rd, 32'hC000_0010);
        reg_write(2'd1, 32'hF);
        run_access(2'd2, 1'b1, 32'hC000_0040, 0, ec, rc, np);
        reg_read(2'd2, rd); chk("R4 new capture", rd, 32'hC000_0040);
        chk("R7 master2 flag", mst_err_irq, 3'b010);

        summary();
        $finish;
    end

endmodule